// File: doc/BRIEF.md
# Multichannel Keyed Sine Synthesizer

This block holds several numerically controlled sine generators that share one clock. Each channel keeps a running phase that grows by a tuning word on every clock and wraps on overflow. A phase offset is added to that phase, and the result drives a quarter-wave sine table. The table output is scaled by an amplitude word and leaves the block as one signed sample per channel per clock.

Each channel holds sixteen stored frequency words, sixteen phase words and sixteen amplitude words. A per-channel key mode chooses which of the three is picked by that channel's 4-bit profile input. This gives 16-level frequency, phase or amplitude keying. The two parameters that are not keyed come from profile 0. A per-channel linear sweep engine can replace the tuning word with a ramp that climbs in fixed steps at a programmed interval and stops at an end value. A shared sync input zeroes every channel's phase on the same edge, so the phase words alone set the relative phase between channels.

Top module: `mc_dds`

## Requirements
- R1: On every clock without sync, a channel's phase register grows by its effective tuning word, modulo 2^PW. The effective word is the sweep value when the channel's sweep is enabled, and the selected frequency word otherwise.
- R2: The sample is formed in these steps:
  - The table address is the top QBITS+2 bits of (phase + selected phase word), modulo 2^PW.
  - Address bit QBITS+1 set means a negative sample. Bit QBITS set means the low QBITS bits are inverted before the lookup.
  - Entry k equals round((2^(DW-1)-1)·sin(π/2·(k+0.5)/2^QBITS)).
  - The signed sample times the unsigned amplitude word is shifted right arithmetically by AMPW.
  - The output at edge k+3 comes from the phase and profile registered at edge k.
- R3: A write is decoded as follows:
  - wr_addr is {channel, kind[2:0], index[3:0]}. The kinds are 0 frequency word, 1 phase word, 2 amplitude word (low AMPW bits), 3 key mode (low 2 bits), 4 sweep step, 5 sweep rate, 6 sweep end, 7 sweep enable (bit 0).
  - Index is used only by kinds 0 to 2.
  - A write changes only the addressed channel and takes effect on the next edge.
- R4: A sync pulse clears every channel's phase register on the same edge.
- R5: The profile input is registered, so a change reaches the datapath one edge after it is sampled. Key mode 0 indexes the frequency word, mode 1 the phase word and mode 2 the amplitude word. The other two parameters come from profile 0.
- R6: With sweep enabled, the sweep value grows by the step once every RATE+1 clocks and never decreases while it is at or below the end value.
- R7: The sweep value stops at the end value. It stops there also when the next step would reach, pass or overflow past it.
- R8: A start pulse loads the sweep value with the channel's selected frequency word and restarts its interval count. This works whether or not sweep is enabled.
- R9: While reset is asserted, all outputs are zero. The phase registers, profile registers and sweep state are zero, key modes are 3 and sweep is disabled.
- R10: Key mode 3 ignores the profile input and takes all three parameters from profile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | CHW+7 | {channel, kind, index} |
| wr_data | input | PW | Write data |
| profile_sel | input | NCH*4 | 4-bit profile per channel, channel 0 in the low bits |
| sync | input | 1 | Clears all phase registers |
| sweep_start | input | NCH | Per-channel sweep reload pulse |
| dout | output | NCH*DW | Signed samples, channel 0 in the low bits |

## Verification
The scoreboard follows the phase of every channel exactly, so an adder that dropped the wrap or a pipeline one stage short or long shows up as sample mismatches within a few clocks. Quadrant handling is exercised by a channel whose tuning word nearly wraps each clock; an inverted mirror bit or sign bit would return the wrong half-wave. Profile changes with every key mode, including mode 3 where the profile must be ignored, catch a profile that takes effect a cycle early or indexes the wrong parameter. The sweep is driven both into a normal end value and into an overflowing step, where a missing carry check would wrap the tuning word to a small value instead of holding.

// File: rtl/mc_dds_pkg.sv
`timescale 1ns/1ps
package mc_dds_pkg;
  typedef enum logic [1:0] {
    KEY_FREQ  = 2'd0,
    KEY_PHASE = 2'd1,
    KEY_AMP   = 2'd2,
    KEY_NONE  = 2'd3
  } key_mode_t;

  typedef enum logic [2:0] {
    RK_FREQ  = 3'd0,
    RK_PHASE = 3'd1,
    RK_AMP   = 3'd2,
    RK_MODE  = 3'd3,
    RK_STEP  = 3'd4,
    RK_RATE  = 3'd5,
    RK_END   = 3'd6,
    RK_SWEN  = 3'd7
  } reg_kind_t;

  localparam int PROF_N = 16;
  localparam int PROF_W = 4;
endpackage

// File: rtl/mc_dds_regs.sv
`timescale 1ns/1ps
module mc_dds_regs
  import mc_dds_pkg::*;
#(
  parameter int PW    = 24,
  parameter int AMPW  = 8,
  parameter int RATEW = 16,
  parameter int CHW   = 2,
  parameter int CH_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CHW+6:0]    wr_addr,
  input  logic [PW-1:0]     wr_data,
  input  logic [PROF_W-1:0] prof,
  output logic [PW-1:0]     ftw_sel,
  output logic [PW-1:0]     pow_sel,
  output logic [AMPW-1:0]   amp_sel,
  output logic [PW-1:0]     sw_step,
  output logic [PW-1:0]     sw_end,
  output logic [RATEW-1:0]  sw_rate,
  output logic              sw_en
);
  logic              hit;
  reg_kind_t         kind;
  logic [PROF_W-1:0] idx;
  key_mode_t         mode;

  logic [PW-1:0]   f_mem [PROF_N];
  logic [PW-1:0]   p_mem [PROF_N];
  logic [AMPW-1:0] a_mem [PROF_N];

  assign hit  = wr_en && (wr_addr[CHW+6:7] == CHW'(CH_ID));
  assign kind = reg_kind_t'(wr_addr[6:4]);
  assign idx  = wr_addr[3:0];

  // profile tables: no reset so they map onto RAM
  always_ff @(posedge clk) begin
    if (hit && kind == RK_FREQ) f_mem[idx] <= wr_data;
  end
  always_ff @(posedge clk) begin
    if (hit && kind == RK_PHASE) p_mem[idx] <= wr_data;
  end
  always_ff @(posedge clk) begin
    if (hit && kind == RK_AMP) a_mem[idx] <= wr_data[AMPW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= KEY_NONE;
      sw_step <= '0;
      sw_end  <= '0;
      sw_rate <= '0;
      sw_en   <= 1'b0;
    end else if (hit) begin
      case (kind)
        RK_MODE: mode    <= key_mode_t'(wr_data[1:0]);
        RK_STEP: sw_step <= wr_data;
        RK_RATE: sw_rate <= wr_data[RATEW-1:0];
        RK_END:  sw_end  <= wr_data;
        RK_SWEN: sw_en   <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    ftw_sel = (mode == KEY_FREQ)  ? f_mem[prof] : f_mem[0];
    pow_sel = (mode == KEY_PHASE) ? p_mem[prof] : p_mem[0];
    amp_sel = (mode == KEY_AMP)   ? a_mem[prof] : a_mem[0];
  end
endmodule

// File: rtl/mc_dds_sweep.sv
`timescale 1ns/1ps
module mc_dds_sweep #(
  parameter int PW    = 24,
  parameter int RATEW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic [PW-1:0]    start_val,
  input  logic [PW-1:0]    step,
  input  logic [PW-1:0]    end_val,
  input  logic [RATEW-1:0] rate,
  output logic [PW-1:0]    cur
);
  logic [RATEW-1:0] cnt;
  logic [PW:0]      sum;
  logic [PW-1:0]    nxt;

  always_comb begin
    sum = {1'b0, cur} + {1'b0, step};
    nxt = (sum[PW] || sum[PW-1:0] >= end_val) ? end_val : sum[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      cnt <= '0;
    end else if (start) begin
      cur <= start_val;
      cnt <= '0;
    end else if (en) begin
      if (cnt >= rate) begin
        cnt <= '0;
        cur <= nxt;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: ramp never moves downward while below or at the end value
  p_sweep_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
    (en && !start && cur <= end_val) |=> (cur >= $past(cur)));

  // R7: once at the end value the ramp holds there
  p_sweep_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !start && cur == end_val) |=> (cur == $past(cur)));

  // R8: a start pulse reloads the ramp
  p_sweep_reload_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> (cur == $past(start_val)));
endmodule

// File: rtl/mc_dds_sine.sv
`timescale 1ns/1ps
module mc_dds_sine #(
  parameter int QBITS = 6,
  parameter int DW    = 12,
  parameter int AMPW  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [QBITS+1:0]     addr_in,
  input  logic [AMPW-1:0]      amp_in,
  output logic signed [DW-1:0] dout
);
  localparam int QN   = 1 << QBITS;
  localparam int PRW  = DW + AMPW + 1;
  localparam int MAXA = (1 << (DW - 1)) - 1;

  function automatic logic [DW-2:0] sine_entry(input int k);
    real ang;
    real mag;
    ang = 3.14159265358979 * (real'(k) + 0.5) / (2.0 * real'(QN));
    mag = (2.0 ** (DW - 1) - 1.0) * $sin(ang);
    return (DW-1)'($rtoi(mag + 0.5));
  endfunction

  logic [DW-2:0] rom [QN];
  for (genvar k = 0; k < QN; k++) begin : g_rom
    assign rom[k] = sine_entry(k);
  end

  logic [QBITS+1:0] addr_q;
  logic [AMPW-1:0]  amp1_q, amp2_q;
  logic [DW-2:0]    mag_q;
  logic             neg_q;
  logic [QBITS-1:0] idx;

  assign idx = addr_q[QBITS] ? ~addr_q[QBITS-1:0] : addr_q[QBITS-1:0];

  logic signed [DW-1:0]  smp;
  logic signed [PRW-1:0] a_ext, b_ext, prod, shifted;

  always_comb begin
    smp     = neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});
    a_ext   = PRW'(smp);
    b_ext   = $signed(PRW'({1'b0, amp2_q}));
    prod    = a_ext * b_ext;
    shifted = prod >>> AMPW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      amp1_q <= '0;
      amp2_q <= '0;
      mag_q  <= '0;
      neg_q  <= 1'b0;
      dout   <= '0;
    end else begin
      addr_q <= addr_in;
      amp1_q <= amp_in;
      mag_q  <= rom[idx];
      neg_q  <= addr_q[QBITS+1];
      amp2_q <= amp1_q;
      dout   <= shifted[DW-1:0];
    end
  end

  // R2: scaled sample never exceeds the table's full-scale magnitude
  p_dout_range_r2: assert property (@(posedge clk) disable iff (rst)
    ($signed(dout) <= MAXA) && ($signed(dout) >= -MAXA));
endmodule

// File: rtl/mc_dds.sv
`timescale 1ns/1ps
module mc_dds
  import mc_dds_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int PW    = 24,
  parameter int QBITS = 6,
  parameter int DW    = 12,
  parameter int AMPW  = 8,
  parameter int RATEW = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)+6:0] wr_addr,
  input  logic [PW-1:0]                         wr_data,
  input  logic [NCH*PROF_W-1:0]                 profile_sel,
  input  logic                                  sync,
  input  logic [NCH-1:0]                        sweep_start,
  output logic [NCH*DW-1:0]                     dout
);
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int ABITS = QBITS + 2;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PROF_W-1:0] prof_q;
    logic [PW-1:0]     ftw_sel, pow_sel, sw_step, sw_end, sw_cur, ftw_eff, acc, phase;
    logic [AMPW-1:0]   amp_sel;
    logic [RATEW-1:0]  sw_rate;
    logic              sw_en;
    logic              unused_low;

    always_ff @(posedge clk) begin
      if (rst) prof_q <= '0;
      else     prof_q <= profile_sel[c*PROF_W +: PROF_W];
    end

    mc_dds_regs #(.PW(PW), .AMPW(AMPW), .RATEW(RATEW), .CHW(CHW), .CH_ID(c)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .prof(prof_q), .ftw_sel(ftw_sel), .pow_sel(pow_sel), .amp_sel(amp_sel),
      .sw_step(sw_step), .sw_end(sw_end), .sw_rate(sw_rate), .sw_en(sw_en)
    );

    mc_dds_sweep #(.PW(PW), .RATEW(RATEW)) u_sweep (
      .clk(clk), .rst(rst), .en(sw_en), .start(sweep_start[c]),
      .start_val(ftw_sel), .step(sw_step), .end_val(sw_end), .rate(sw_rate),
      .cur(sw_cur)
    );

    assign ftw_eff = sw_en ? sw_cur : ftw_sel;

    always_ff @(posedge clk) begin
      if (rst || sync) acc <= '0;
      else             acc <= acc + ftw_eff;
    end

    assign phase      = acc + pow_sel;
    assign unused_low = ^phase[PW-ABITS-1:0];

    mc_dds_sine #(.QBITS(QBITS), .DW(DW), .AMPW(AMPW)) u_sine (
      .clk(clk), .rst(rst), .addr_in(phase[PW-1 -: ABITS]), .amp_in(amp_sel),
      .dout(dout[c*DW +: DW])
    );

    // R4: sync leaves every phase register at zero on the following edge
    p_sync_clears_r4: assert property (@(posedge clk) disable iff (rst)
      sync |=> (acc == '0));
  end
endmodule

// File: tb/mc_dds_tb.sv
`timescale 1ns/1ps
module mc_dds_tb;
  localparam int NCH = 4, PW = 24, QBITS = 6, DW = 12, AMPW = 8, RATEW = 16;
  localparam int CHW = 2, AW = CHW + 7, ABITS = QBITS + 2, QN = 1 << QBITS;
  localparam longint MASK = (64'd1 << PW) - 1;

  logic clk = 1'b0;
  logic rst, wr_en, sync;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] wr_data;
  logic [NCH*4-1:0] profile_sel;
  logic [NCH-1:0] sweep_start;
  logic [NCH*DW-1:0] dout;

  always #5 clk = ~clk;

  mc_dds #(.NCH(NCH), .PW(PW), .QBITS(QBITS), .DW(DW), .AMPW(AMPW), .RATEW(RATEW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .profile_sel(profile_sel), .sync(sync), .sweep_start(sweep_start), .dout(dout)
  );

  // reference state built from the requirements
  longint fr [NCH][16];
  longint ph [NCH][16];
  int     am [NCH][16];
  int     md [NCH];
  longint stp [NCH], endv [NCH], acc_m [NCH], cur_m [NCH];
  int     rate [NCH], cnt_m [NCH], prof_m [NCH];
  bit     swen [NCH];

  logic [NCH*DW-1:0] exp_q[$];
  string tag_q[$];
  string cur_tag = "R9";
  bit sb_on = 0, done = 0;
  int n_vec = 0, n_bad = 0;

  function automatic int tbl(int k);
    real v;
    v = (2.0 ** (DW - 1) - 1.0) * $sin(3.14159265358979 * (real'(k) + 0.5) / (2.0 * real'(QN)));
    return $rtoi(v + 0.5);
  endfunction

  // R2 reference sample for one channel from the current reference state
  function automatic logic [DW-1:0] expect_ch(int c);
    longint psel, phs;
    int asel, a, q, m, s, r;
    psel = (md[c] == 1) ? ph[c][prof_m[c]] : ph[c][0];
    asel = (md[c] == 2) ? am[c][prof_m[c]] : am[c][0];
    phs  = (acc_m[c] + psel) & MASK;
    a    = int'(phs >> (PW - ABITS));
    q    = a % QN;
    if (((a >> QBITS) & 1) == 1) q = QN - 1 - q;
    m    = tbl(q);
    s    = (((a >> (QBITS + 1)) & 1) == 1) ? -m : m;
    r    = (s * asel) >>> AMPW;
    return DW'(r);
  endfunction

  task automatic advance();
    for (int c = 0; c < NCH; c++) begin
      longint fsel, feff, sum;
      fsel = (md[c] == 0) ? fr[c][prof_m[c]] : fr[c][0];
      feff = swen[c] ? cur_m[c] : fsel;
      acc_m[c] = sync ? 0 : ((acc_m[c] + feff) & MASK);     // R1, R4
      if (sweep_start[c]) begin                               // R8
        cur_m[c] = fsel; cnt_m[c] = 0;
      end else if (swen[c]) begin                             // R6, R7
        if (cnt_m[c] >= rate[c]) begin
          cnt_m[c] = 0;
          sum = cur_m[c] + stp[c];
          cur_m[c] = (sum > MASK || sum >= endv[c]) ? endv[c] : sum;
        end else cnt_m[c]++;
      end
      prof_m[c] = int'(profile_sel[c*4 +: 4]);                // R5
    end
    if (wr_en) begin                                          // R3
      int c, k, i;
      c = int'(wr_addr[AW-1:7]); k = int'(wr_addr[6:4]); i = int'(wr_addr[3:0]);
      case (k)
        0: fr[c][i] = longint'(wr_data);
        1: ph[c][i] = longint'(wr_data);
        2: am[c][i] = int'(wr_data[AMPW-1:0]);
        3: md[c]    = int'(wr_data[1:0]);
        4: stp[c]   = longint'(wr_data);
        5: rate[c]  = int'(wr_data[RATEW-1:0]);
        6: endv[c]  = longint'(wr_data);
        default: swen[c] = wr_data[0];
      endcase
    end
  endtask

  // driver pushes the expected item; monitor side pops the item due now
  task automatic tick();
    logic [NCH*DW-1:0] e, got_all;
    string t;
    if (sb_on) begin
      for (int c = 0; c < NCH; c++) e[c*DW +: DW] = expect_ch(c);
      exp_q.push_back(e);
      tag_q.push_back(cur_tag);
      if (exp_q.size() == 4) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got_all = dout;
        for (int c = 0; c < NCH; c++) begin
          n_vec++;
          if (got_all[c*DW +: DW] !== e[c*DW +: DW]) begin
            n_bad++;
            $display("FAIL %s ch%0d actual %0d expected %0d", t, c,
                     $signed(got_all[c*DW +: DW]), $signed(e[c*DW +: DW]));
          end
        end
      end
    end
    advance();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int c, int kind, int idx, longint data);
    wr_en = 1'b1;
    wr_addr = {c[CHW-1:0], kind[2:0], idx[3:0]};
    wr_data = data[PW-1:0];
    tick();
    wr_en = 1'b0;
  endtask

  task automatic check_zero(string t);
    for (int c = 0; c < NCH; c++) begin
      n_vec++;
      if (dout[c*DW +: DW] !== '0) begin
        n_bad++;
        $display("FAIL %s ch%0d actual %0d expected 0", t, c, $signed(dout[c*DW +: DW]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; sync = 1'b0; wr_addr = '0; wr_data = '0;
    profile_sel = '0; sweep_start = '0;
    for (int c = 0; c < NCH; c++) begin
      md[c] = 3; stp[c] = 0; endv[c] = 0; rate[c] = 0; swen[c] = 0;
      acc_m[c] = 0; cur_m[c] = 0; cnt_m[c] = 0; prof_m[c] = 0;
      for (int i = 0; i < 16; i++) begin fr[c][i] = 0; ph[c][i] = 0; am[c][i] = 0; end
    end
    repeat (3) @(negedge clk);
    check_zero("R9");                 // R9: outputs zero under reset
    rst = 1'b0;
    check_zero("R9");

    // R3: load every profile of every channel
    cur_tag = "R3";
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 16; i++) begin
        wr(c, 0, i, (c == 3 && i == 0) ? 64'hF35000 : (longint'(c + 1) * 64'h011000 + longint'(i) * 64'h2345));
        wr(c, 1, i, longint'(i) << (PW - 4));
        wr(c, 2, i, 255 - i * 15);
      end

    // R4: align all channels, then start the scoreboard
    sync = 1'b1; tick(); sync = 1'b0;
    sb_on = 1'b1;
    cur_tag = "R1";
    repeat (40) tick();

    // R10: mode 3 ignores the profile input
    cur_tag = "R10";
    for (int i = 0; i < 20; i++) begin
      profile_sel = 16'h9E37 * (i + 1);
      tick();
    end

    // R5: frequency, phase and amplitude keying on channels 0..2
    cur_tag = "R3";
    wr(0, 3, 0, 0); wr(1, 3, 0, 1); wr(2, 3, 0, 2);
    cur_tag = "R5";
    for (int i = 0; i < 48; i++) begin
      profile_sel = {4'(i * 5), 4'(i * 3 + 1), 4'(i * 7 + 2), 4'(i)};
      tick();
    end

    // R3: rewriting channel 2's live amplitude word leaves others alone
    profile_sel = 16'h3555;
    cur_tag = "R3";
    repeat (4) tick();
    wr(2, 2, 5, 64'h40);
    wr(1, 2, 6, 64'h11);
    repeat (8) tick();

    // R4: mid-run sync
    cur_tag = "R4";
    sync = 1'b1; tick(); sync = 1'b0;
    repeat (12) tick();

    // R6/R7: sweep on channel 3 toward an end value
    cur_tag = "R6";
    wr(3, 4, 0, 64'h004000);
    wr(3, 5, 0, 2);
    wr(3, 6, 0, 64'hF48000);
    wr(3, 7, 0, 1);
    sweep_start = 4'b1000; tick(); sweep_start = '0;
    repeat (14) tick();
    cur_tag = "R7";
    repeat (12) tick();

    // R7: step that would overflow past the end value
    wr(3, 4, 0, 64'h0C0000);
    wr(3, 5, 0, 0);
    wr(3, 6, 0, 64'hFFFFFF);
    sweep_start = 4'b1000; tick(); sweep_start = '0;
    repeat (10) tick();

    // R8: start pulse mid-ramp reloads the start word
    cur_tag = "R8";
    wr(3, 4, 0, 64'h001000);
    wr(3, 5, 0, 1);
    repeat (5) tick();
    sweep_start = 4'b1000; tick(); sweep_start = '0;
    repeat (10) tick();

    // R6: sweep disabled returns to the stored word
    cur_tag = "R6";
    wr(3, 7, 0, 0);
    repeat (10) tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule